// File: doc/BRIEF.md
# RISC Next Program Counter Unit

This unit holds the program counter of a 32-bit RISC core with fixed-length, word-aligned instructions. Each cycle it chooses the following fetch address. The choices are the plain sequential step, a PC-relative conditional branch, a region-preserving absolute jump, or a jump through a register. It also drives the write port request that saves the return address for the linking forms.

The decoder supplies a 3-bit control class, the 16-bit immediate, the 26-bit jump index and the two register operand values. The unit presents the next PC and the link write request combinationally. It loads the next PC into its register on a clock edge only when `advance` is high. A register target that is not word-aligned is refused. The unit raises a flag, suppresses the link write and keeps the PC where it is.

Top module: `npc_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it, `pc` reads 0x0000_0000.
- R2: Class 0 (sequential), and the reserved class 7, give `next_pc` = `pc` + 4. On a rising edge with `advance` high, `pc` takes `next_pc`. With `advance` low, `pc` holds its value.
- R3: Class 1 (branch if equal) gives `pc` + 4 + 4×sext(`imm16`) when `opa` == `opb`, and `pc` + 4 otherwise.
- R4: Class 2 (branch if not equal) gives `pc` + 4 + 4×sext(`imm16`) when `opa` != `opb`, and `pc` + 4 otherwise.
- R5: A negative immediate moves the target backward. All address sums wrap modulo 2^32, so sequential from 0xFFFF_FFFC gives 0.
- R6: Class 3 (jump) gives {(`pc`+4)[31:28], `jidx`, 2'b00} and requests no link write.
- R7: Class 4 (jump and link) gives the R6 target, `link_we` = 1, `link_idx` = 31 and `link_val` = `pc` + 4.
- R8: Class 5 (jump register) gives `next_pc` = `opa` and requests no link write.
- R9: Class 6 (jump and link register) gives `next_pc` = `opa` and `link_we` = 1. `link_idx` = `link_sel`, or 31 when `link_sel` is 0. `link_val` = `pc` + 4.
- R10: For class 5 or 6 with `opa`[1:0] != 0, `align_err` = 1, `next_pc` = `pc`, `link_we` = 0, and `pc` is unchanged by an advance.
- R11: `link_we` is 1 only for classes 4 and 6. `align_err` is 0 for every class other than 5 and 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| advance | input | 1 | Load next PC on this edge |
| ctl_class | input | 3 | Control class (0 seq, 1 beq, 2 bne, 3 jump, 4 jump-link, 5 jump-reg, 6 jump-link-reg, 7 reserved) |
| imm16 | input | 16 | Branch word offset, signed |
| jidx | input | 26 | Absolute jump word index |
| opa | input | 32 | First register operand, also register target |
| opb | input | 32 | Second register operand |
| link_sel | input | 5 | Link destination for class 6, 0 selects default |
| pc | output | 32 | Current program counter |
| next_pc | output | 32 | Address the PC takes on advance |
| link_we | output | 1 | Return-address write request |
| link_idx | output | 5 | Return-address register index |
| link_val | output | 32 | Return address (PC + 4) |
| align_err | output | 1 | Misaligned register target |

## Verification
The situations hardest to reach from the ports are the region-preserving jump and the wrap at the top of the address space. Both need the PC to sit at a high address first, and the PC starts at zero and only moves in small steps. The stimulus uses a jump register to place the PC near 0xA000_0000 and then issues an absolute jump, so the kept upper nibble is non-zero. It then uses a jump register to 0xFFFF_FFFC followed by a sequential step to observe the wrap. A misaligned jump register is issued with `advance` high, so the refusal shows up as an unchanged `pc`.

// File: rtl/npc_pkg.sv
package npc_pkg;
    typedef enum logic [2:0] {
        CL_SEQ  = 3'd0,
        CL_BEQ  = 3'd1,
        CL_BNE  = 3'd2,
        CL_JMP  = 3'd3,
        CL_JAL  = 3'd4,
        CL_JR   = 3'd5,
        CL_JALR = 3'd6,
        CL_RSV  = 3'd7
    } ctl_class_e;
endpackage

// File: rtl/npc_incr.sv
module npc_incr #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 16
) (
    input  logic [XLEN-1:0]  pc_i,
    input  logic [IMM_W-1:0] imm_i,
    output logic [XLEN-1:0]  pc_plus4_o,
    output logic [XLEN-1:0]  br_tgt_o
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] imm_sx;

    // Sign-extended word offset, later scaled to bytes.
    assign imm_sx     = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
    assign pc_plus4_o = pc_i + XLEN'(4);
    assign br_tgt_o   = pc_plus4_o + (imm_sx << 2);
endmodule

// File: rtl/npc_cmp.sv
module npc_cmp #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] opa_i,
    input  logic [XLEN-1:0] opb_i,
    output logic            eq_o
);
    logic [XLEN-1:0] diff;

    assign diff = opa_i ^ opb_i;
    assign eq_o = ~|diff;
endmodule

// File: rtl/npc_jform.sv
module npc_jform #(
    parameter int XLEN   = 32,
    parameter int JIDX_W = 26
) (
    input  logic [XLEN-1:0]   pc_plus4_i,
    input  logic [JIDX_W-1:0] jidx_i,
    output logic [XLEN-1:0]   jtgt_o
);
    localparam int HI_W = XLEN - JIDX_W - 2;

    generate
        if (HI_W > 0) begin : g_region
            assign jtgt_o = {pc_plus4_i[XLEN-1 -: HI_W], jidx_i, 2'b00};
        end else begin : g_flat
            assign jtgt_o = {jidx_i, 2'b00};
        end
    endgenerate
endmodule

// File: rtl/npc_unit.sv
module npc_unit #(
    parameter int          XLEN      = 32,
    parameter int          IMM_W     = 16,
    parameter int          JIDX_W    = 26,
    parameter int          REG_W     = 5,
    parameter int          LINK_DFLT = 31,
    parameter logic [31:0] RESET_PC  = 32'h0000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance,
    input  logic [2:0]        ctl_class,
    input  logic [IMM_W-1:0]  imm16,
    input  logic [JIDX_W-1:0] jidx,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [REG_W-1:0]  link_sel,
    output logic [XLEN-1:0]   pc,
    output logic [XLEN-1:0]   next_pc,
    output logic              link_we,
    output logic [REG_W-1:0]  link_idx,
    output logic [XLEN-1:0]   link_val,
    output logic              align_err
);
    import npc_pkg::*;

    localparam logic [REG_W-1:0] LINK_IDX_DFLT = REG_W'(LINK_DFLT);

    typedef struct packed {
        logic [XLEN-1:0]  pc;
        logic             link_we;
        logic [REG_W-1:0] link_idx;
        logic             align_err;
    } step_t;

    ctl_class_e      cls;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_plus4;
    logic [XLEN-1:0] br_tgt;
    logic [XLEN-1:0] j_tgt;
    logic            ops_eq;
    logic            reg_misal;
    step_t           st_d;

    assign cls = ctl_class_e'(ctl_class);

    npc_incr #(.XLEN(XLEN), .IMM_W(IMM_W)) u_incr (
        .pc_i       (pc_q),
        .imm_i      (imm16),
        .pc_plus4_o (pc_plus4),
        .br_tgt_o   (br_tgt)
    );

    npc_cmp #(.XLEN(XLEN)) u_cmp (
        .opa_i (opa),
        .opb_i (opb),
        .eq_o  (ops_eq)
    );

    npc_jform #(.XLEN(XLEN), .JIDX_W(JIDX_W)) u_jform (
        .pc_plus4_i (pc_plus4),
        .jidx_i     (jidx),
        .jtgt_o     (j_tgt)
    );

    assign reg_misal = |opa[1:0];

    always_comb begin
        st_d           = '0;
        st_d.pc        = pc_plus4;
        st_d.link_idx  = LINK_IDX_DFLT;
        unique case (cls)
            CL_BEQ:  st_d.pc = ops_eq ? br_tgt : pc_plus4;
            CL_BNE:  st_d.pc = ops_eq ? pc_plus4 : br_tgt;
            CL_JMP:  st_d.pc = j_tgt;
            CL_JAL: begin
                st_d.pc      = j_tgt;
                st_d.link_we = 1'b1;
            end
            CL_JR, CL_JALR: begin
                if (reg_misal) begin
                    st_d.pc        = pc_q;
                    st_d.align_err = 1'b1;
                end else begin
                    st_d.pc      = opa;
                    st_d.link_we = (cls == CL_JALR);
                    if (link_sel != '0) st_d.link_idx = link_sel;
                end
            end
            default: st_d.pc = pc_plus4;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= XLEN'(RESET_PC);
        end else if (advance) begin
            pc_q <= st_d.pc;
        end
    end

    assign pc        = pc_q;
    assign next_pc   = st_d.pc;
    assign link_we   = st_d.link_we;
    assign link_idx  = st_d.link_idx;
    assign link_val  = pc_plus4;
    assign align_err = st_d.align_err;

    // R2: without an advance strobe the PC register holds.
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(pc_q));

    // R2: the PC stays word-aligned.
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pc_q[1:0] == 2'b00);

    // R4: a taken not-equal branch lands on the branch adder result.
    a_r4_bne_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && cls == CL_BNE && !ops_eq) |=> pc_q == $past(br_tgt));

    // R10: a refused register target leaves the PC in place.
    a_r10_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && align_err) |=> $stable(pc_q));

    // R11: link writes only come from the linking classes.
    a_r11_link_only: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> (cls == CL_JAL || cls == CL_JALR));

    // R7: the jump-and-link form always names the default register.
    a_r7_jal_idx: assert property (@(posedge clk) disable iff (!rst_n)
        (link_we && cls == CL_JAL) |-> link_idx == LINK_IDX_DFLT);
endmodule

// File: tb/tb_npc_unit.sv
module tb_npc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        advance = 1'b0;
    logic [2:0]  ctl_class = 3'd0;
    logic [15:0] imm16 = '0;
    logic [25:0] jidx = '0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic [4:0]  link_sel = '0;
    logic [31:0] pc, next_pc, link_val;
    logic        link_we, align_err;
    logic [4:0]  link_idx;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [31:0] npc;
        logic        we;
        logic [4:0]  idx;
        logic [31:0] val;
        logic        err;
        logic [31:0] pc_after;
        string       tag;
    } exp_t;

    exp_t sb[$];
    logic [31:0] model_pc = 32'h0;

    always #10 clk = ~clk;

    npc_unit dut (
        .clk(clk), .rst_n(rst_n), .advance(advance), .ctl_class(ctl_class),
        .imm16(imm16), .jidx(jidx), .opa(opa), .opb(opb), .link_sel(link_sel),
        .pc(pc), .next_pc(next_pc), .link_we(link_we), .link_idx(link_idx),
        .link_val(link_val), .align_err(align_err)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: applies one control step at a falling edge and records the expectation.
    task automatic drive(input string tag, input logic [2:0] cls, input logic [15:0] im,
                         input logic [25:0] ji, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] ls, input logic adv);
        exp_t e;
        logic [31:0] p4, off;
        @(negedge clk);
        ctl_class = cls; imm16 = im; jidx = ji; opa = a; opb = b;
        link_sel = ls; advance = adv;
        p4  = model_pc + 32'd4;
        off = {{14{im[15]}}, im, 2'b00};
        e.npc = p4; e.we = 1'b0; e.idx = 5'd31; e.val = p4; e.err = 1'b0; e.tag = tag;
        case (cls)
            3'd1: if (a == b) e.npc = p4 + off;
            3'd2: if (a != b) e.npc = p4 + off;
            3'd3: e.npc = {p4[31:28], ji, 2'b00};
            3'd4: begin e.npc = {p4[31:28], ji, 2'b00}; e.we = 1'b1; end
            3'd5, 3'd6: begin
                if (a[1:0] != 2'b00) begin
                    e.npc = model_pc; e.err = 1'b1;
                end else begin
                    e.npc = a;
                    e.we  = (cls == 3'd6);
                    if (ls != 5'd0) e.idx = ls;
                end
            end
            default: e.npc = p4;
        endcase
        if (adv) model_pc = e.npc;
        e.pc_after = model_pc;
        sb.push_back(e);
        @(posedge clk);
    endtask

    // Monitor: compares combinational outputs mid-cycle and the PC after the edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                check(next_pc == e.npc, e.tag, "next_pc", next_pc, e.npc);
                check(link_we == e.we, e.tag, "link_we", 32'(link_we), 32'(e.we));
                if (e.we) begin
                    check(link_idx == e.idx, e.tag, "link_idx", 32'(link_idx), 32'(e.idx));
                    check(link_val == e.val, e.tag, "link_val", link_val, e.val);
                end
                check(align_err == e.err, e.tag, "align_err", 32'(align_err), 32'(e.err));
                @(posedge clk);
                #1;
                check(pc == e.pc_after, e.tag, "pc", pc, e.pc_after);
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(pc == 32'h0, "R1", "pc in reset", pc, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(pc == 32'h0, "R1", "pc after reset", pc, 32'h0);

        drive("R2", 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 5'd0, 1'b1);
        drive("R2", 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 5'd0, 1'b0);
        drive("R2", 3'd7, 16'h0, 26'h0, 32'h0, 32'h0, 5'd0, 1'b1);
        drive("R3", 3'd1, 16'h0010, 26'h0, 32'h55, 32'h55, 5'd0, 1'b1);
        drive("R3", 3'd1, 16'h0010, 26'h0, 32'h55, 32'h56, 5'd0, 1'b1);
        drive("R4", 3'd2, 16'h0004, 26'h0, 32'h1, 32'h2, 5'd0, 1'b1);
        drive("R4", 3'd2, 16'h0004, 26'h0, 32'h7, 32'h7, 5'd0, 1'b1);
        drive("R5", 3'd1, 16'hFFF8, 26'h0, 32'h9, 32'h9, 5'd0, 1'b1);
        drive("R8", 3'd5, 16'h0, 26'h0, 32'hA000_0010, 32'h0, 5'd3, 1'b1);
        drive("R6", 3'd3, 16'h0, 26'h123_4567, 32'h0, 32'h0, 5'd0, 1'b1);
        drive("R7", 3'd4, 16'h0, 26'h000_0040, 32'h0, 32'h0, 5'd0, 1'b1);
        drive("R9", 3'd6, 16'h0, 26'h0, 32'h0000_0400, 32'h0, 5'd7, 1'b1);
        drive("R9", 3'd6, 16'h0, 26'h0, 32'h0000_0800, 32'h0, 5'd0, 1'b1);
        drive("R10", 3'd5, 16'h0, 26'h0, 32'h0000_1002, 32'h0, 5'd0, 1'b1);
        drive("R10", 3'd6, 16'h0, 26'h0, 32'h0000_1001, 32'h0, 5'd9, 1'b1);
        drive("R11", 3'd3, 16'h0, 26'h0, 32'h0000_0003, 32'h0, 5'd4, 1'b1);
        drive("R5", 3'd5, 16'h0, 26'h0, 32'hFFFF_FFFC, 32'h0, 5'd0, 1'b1);
        drive("R5", 3'd0, 16'h0, 26'h0, 32'h0, 32'h0, 5'd0, 1'b1);

        @(negedge clk);
        advance = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check(sb.size() == 0, "R2", "scoreboard drained", 32'(sb.size()), 32'h0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule